// File: doc/BRIEF.md
# PCM Master Clock Mode Selector

This block sits in the digital core of a telephony PCM codec. It watches the clock-select pin, which is shared with the receive bit clock. From that pin it works out whether the receive path shares the transmit master clock (synchronous) or runs on its own (asynchronous). It also picks how many master-clock cycles make one 8 kHz frame, and it produces a one-cycle frame tick from the transmit master clock.

The pin is sampled in fixed windows of master-clock cycles. A window with enough edges means the pin is toggling; otherwise the pin is taken as static at its level at the end of the window. A class only takes effect after two windows in a row agree. The meaning of a static level depends on the companding variant: the mu-law and A-law variants map it in opposite ways.

In the 1.536/1.544 MHz family, the block measures the spacing of transmit frame sync pulses to tell the two rates apart. A 193-cycle spacing selects a 193-cycle frame, which takes up the extra pulse each frame carries at 1.544 MHz. The block has only plain control and status pins: it carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pcm_clk_mode_sel`

## Requirements
- R1: After reset, the pin class is static high: `mode_async`=0 and `frame_tick`=0. `ratio` is 192 when `alaw`=0 and 256 when `alaw`=1.
- R2: With `alaw`=0, a select pin held low gives `mode_async`=0 and `ratio`=256.
- R3: With `alaw`=0, a select pin held high gives `mode_async`=0 and `ratio` in the 192/193 family.
- R4: With `alaw`=1 the mapping is reversed: held low gives `ratio` in the 192/193 family, and held high gives `ratio`=256. Both cases give `mode_async`=0.
- R5: A window of 64 master-clock cycles that holds at least 4 pin edges classes the pin as toggling. A toggling pin gives `mode_async`=1 and the variant's native ratio: the 192/193 family for `alaw`=0 and 256 for `alaw`=1.
- R6: A new class takes effect only at the end of the second of two consecutive windows that agree on it. A burst of at most 6 edges therefore never sets `mode_async`.
- R7: Within the 192/193 family, a measured spacing of 193 cycles between rising edges of `fsx` selects 193. A spacing of 192 selects 192. Any other spacing leaves the choice unchanged.
- R8: `frame_tick` is a one-cycle pulse that repeats every `ratio` cycles.
- R9: `rx_clk_shared` is 1 exactly when the mode is synchronous and the synchronized `rx_mclk_pdn` is low.
- R10: `ratio` is always one of 192, 193 or 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit master clock |
| rst_n | input | 1 | Active-low reset |
| alaw | input | 1 | Variant strap: 0 = mu-law, 1 = A-law |
| sel_pin | input | 1 | Clock-select / receive bit-clock pin, asynchronous |
| fsx | input | 1 | Transmit frame sync |
| rx_mclk_pdn | input | 1 | Receive master-clock / power-down pin level |
| mode_async | output | 1 | 1 = receive path runs asynchronously |
| ratio | output | 9 | Master-clock cycles per frame |
| frame_tick | output | 1 | One-cycle pulse per frame |
| rx_clk_shared | output | 1 | Receive path uses the transmit master clock |

## Verification
A wrong window count or class register shows up at the ports as a wrong `mode_async` or `ratio`. That error appears within two or three windows, which is about 200 cycles. A bad frame-length measurement changes the spacing of `frame_tick` within one frame after the next `fsx` edge, and the bench measures that spacing directly. A stability check that is too loose lets a short burst flip `mode_async`, and the bench watches every cycle of the burst to catch it.

// File: rtl/pcm_clk_pkg.sv
package pcm_clk_pkg;
  typedef enum logic [1:0] {
    SEL_LOW    = 2'd0,
    SEL_HIGH   = 2'd1,
    SEL_TOGGLE = 2'd2
  } sel_class_e;

  localparam int RATIO_W   = 9;
  localparam int RATIO_FAST = 256;
  localparam int RATIO_T1   = 193;
  localparam int RATIO_BASE = 192;
endpackage

// File: rtl/sel_classifier.sv
module sel_classifier
  import pcm_clk_pkg::*;
#(
  parameter int WIN_CYC  = 64,
  parameter int EDGE_MIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_pin,
  output sel_class_e cls
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(WIN_CYC + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);

  logic          s_meta, s_sync, s_prev;
  logic [WW-1:0] wcnt;
  logic [EW-1:0] ecnt;
  logic          edge_seen, win_end;
  logic [EW-1:0] ecnt_total;
  sel_class_e    win_cls, last_cls, cls_q;

  assign edge_seen  = s_sync ^ s_prev;
  assign win_end    = (wcnt == WLAST);
  assign ecnt_total = ecnt + EW'(edge_seen);

  always_comb begin
    if (ecnt_total >= EW'(EDGE_MIN)) win_cls = SEL_TOGGLE;
    else if (s_sync)                 win_cls = SEL_HIGH;
    else                             win_cls = SEL_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta   <= 1'b1;
      s_sync   <= 1'b1;
      s_prev   <= 1'b1;
      wcnt     <= '0;
      ecnt     <= '0;
      last_cls <= SEL_HIGH;
      cls_q    <= SEL_HIGH;
    end else begin
      s_meta <= sel_pin;
      s_sync <= s_meta;
      s_prev <= s_sync;
      wcnt   <= win_end ? '0 : wcnt + 1'b1;
      if (win_end) begin
        ecnt     <= '0;
        last_cls <= win_cls;
        if (win_cls == last_cls) cls_q <= win_cls;
      end else begin
        ecnt <= ecnt_total;
      end
    end
  end

  assign cls = cls_q;

  // R6: the committed class moves only on a window boundary
  p_class_at_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cls_q) |-> $past(win_end));
  // R6: a commit needs the previous window to have agreed
  p_class_agrees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cls_q) |-> (cls_q == $past(last_cls)));
endmodule

// File: rtl/frame_len_meas.sv
module frame_len_meas #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsx,
  output logic is_long
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             f_meta, f_sync, f_prev, seen_first, fs_rise;
  logic [CNT_W-1:0] cnt;

  assign fs_rise = f_sync & ~f_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_meta     <= 1'b0;
      f_sync     <= 1'b0;
      f_prev     <= 1'b0;
      seen_first <= 1'b0;
      cnt        <= '0;
      is_long    <= 1'b0;
    end else begin
      f_meta <= fsx;
      f_sync <= f_meta;
      f_prev <= f_sync;
      if (fs_rise) begin
        cnt        <= CNT_W'(1);
        seen_first <= 1'b1;
        if (seen_first) begin
          if (cnt == CNT_W'(193))      is_long <= 1'b1;
          else if (cnt == CNT_W'(192)) is_long <= 1'b0;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: the length choice changes only after a frame-sync rising edge
  p_len_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(is_long) |-> $past(fs_rise));
endmodule

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  output logic          tick
);
  logic [RW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= wrap ? '0 : cnt + 1'b1;
  end

  assign tick = wrap;

  // R8: the tick lasts exactly one cycle
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pcm_clk_mode_sel.sv
module pcm_clk_mode_sel
  import pcm_clk_pkg::*;
#(
  parameter int WIN_CYC  = 64,
  parameter int EDGE_MIN = 4,
  parameter int CNT_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alaw,
  input  logic               sel_pin,
  input  logic               fsx,
  input  logic               rx_mclk_pdn,
  output logic               mode_async,
  output logic [RATIO_W-1:0] ratio,
  output logic               frame_tick,
  output logic               rx_clk_shared
);
  sel_class_e cls;
  logic       is_long, use_fast;
  logic       pdn_meta, pdn_sync;

  sel_classifier #(.WIN_CYC(WIN_CYC), .EDGE_MIN(EDGE_MIN)) cls_i (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .cls(cls));

  frame_len_meas #(.CNT_W(CNT_W)) meas_i (
    .clk(clk), .rst_n(rst_n), .fsx(fsx), .is_long(is_long));

  always_comb begin
    unique case (cls)
      SEL_TOGGLE: use_fast = alaw;
      SEL_LOW:    use_fast = ~alaw;
      default:    use_fast = alaw;
    endcase
  end

  assign mode_async = (cls == SEL_TOGGLE);
  assign ratio = use_fast ? RATIO_W'(RATIO_FAST)
               : (is_long ? RATIO_W'(RATIO_T1) : RATIO_W'(RATIO_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_meta <= 1'b1;
      pdn_sync <= 1'b1;
    end else begin
      pdn_meta <= rx_mclk_pdn;
      pdn_sync <= pdn_meta;
    end
  end

  assign rx_clk_shared = ~mode_async & ~pdn_sync;

  frame_divider #(.RW(RATIO_W)) div_i (
    .clk(clk), .rst_n(rst_n), .ratio(ratio), .tick(frame_tick));

  // R10: only the three frame lengths ever appear
  p_ratio_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == 9'd192) || (ratio == 9'd193) || (ratio == 9'd256));
  // R5: asynchronous operation uses the native rate of the variant
  p_async_native_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_async |-> ((ratio == 9'd256) == alaw));
  // R9: sharing the transmit clock excludes asynchronous operation
  p_shared_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_shared |-> !mode_async);
endmodule

// File: tb/pcm_clk_mode_sel_tb.sv
module pcm_clk_mode_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alaw = 1'b0;
  logic       sel_pin = 1'b1;
  logic       fsx = 1'b0;
  logic       rx_mclk_pdn = 1'b0;
  logic       mode_async, frame_tick, rx_clk_shared;
  logic [8:0] ratio;

  int n_tests = 0;
  int n_fail  = 0;
  int pat = 1;     // 0 low, 1 high, 2 toggle, 3 manual
  int per = 192;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_clk_mode_sel dut_i (
    .clk(clk), .rst_n(rst_n), .alaw(alaw), .sel_pin(sel_pin), .fsx(fsx),
    .rx_mclk_pdn(rx_mclk_pdn), .mode_async(mode_async), .ratio(ratio),
    .frame_tick(frame_tick), .rx_clk_shared(rx_clk_shared));

  // pin stimulus driven on the falling edge
  initial begin
    int tc = 0;
    int fc = 0;
    forever begin
      @(negedge clk);
      tc++;
      if (pat == 2) begin
        if (tc % 4 == 0) sel_pin = ~sel_pin;
      end else if (pat != 3) begin
        sel_pin = pat[0];
      end
      fsx = (fc == 0);
      fc  = (fc + 1 >= per) ? 0 : fc + 1;
    end
  end

  function automatic int exp_ratio(bit a, int p, int fp, bit long_prev);
    bit fast;
    bit lng;
    if (p == 2)      fast = a;
    else if (p == 0) fast = ~a;
    else             fast = a;
    lng = (fp == 193) ? 1'b1 : (fp == 192) ? 1'b0 : long_prev;
    return fast ? 256 : (lng ? 193 : 192);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_gap(output int gap);
    gap = 0;
    while (frame_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (frame_tick !== 1'b1) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic run_cfg(string req, bit a, int p, int fp, bit pd, inout bit long_st);
    int g;
    int e;
    alaw = a; pat = p; per = fp; rx_mclk_pdn = pd;
    repeat (600) @(negedge clk);
    e = exp_ratio(a, p, fp, long_st);
    if (e != 256) long_st = (e == 193);
    check({req, " ratio"}, ratio, e);
    check({req, " mode_async"}, mode_async, (p == 2));
    check({req, " R9 rx_clk_shared"}, rx_clk_shared, (p != 2) && !pd);
    tick_gap(g);
    check({req, " R8 tick gap"}, g, e);
  endtask

  initial begin
    bit long_st = 0;
    int g;
    int seen_async;
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mode_async", mode_async, 0);
    check("R1 frame_tick", frame_tick, 0);
    check("R1 ratio mu", ratio, 192);
    alaw = 1'b1; #1;
    check("R1 ratio A", ratio, 256);
    alaw = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    run_cfg("R2 mu low",    0, 0, 192, 0, long_st);
    run_cfg("R3 mu high",   0, 1, 192, 0, long_st);
    run_cfg("R4 A low",     1, 0, 192, 0, long_st);
    run_cfg("R4 A high",    1, 1, 192, 1, long_st);
    run_cfg("R5 mu toggle", 0, 2, 192, 0, long_st);
    run_cfg("R5 A toggle",  1, 2, 192, 0, long_st);
    run_cfg("R7 mu 193",    0, 1, 193, 0, long_st);
    run_cfg("R7 odd len",   0, 1, 200, 0, long_st);
    run_cfg("R7 back 192",  0, 1, 192, 0, long_st);

    // R6: a short burst must not switch to asynchronous operation
    pat = 3; sel_pin = 1'b1; seen_async = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sel_pin = ~sel_pin;
      @(negedge clk);
      if (mode_async) seen_async++;
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mode_async) seen_async++;
    end
    check("R6 burst async cycles", seen_async, 0);
    check("R6 ratio held", ratio, 192);

    // randomized configurations
    for (int k = 0; k < 14; k++) begin
      bit a;
      int p;
      int fp;
      bit pd;
      a  = $urandom_range(1, 0);
      p  = $urandom_range(2, 0);
      fp = ($urandom_range(1, 0) == 1) ? 193 : 192;
      pd = $urandom_range(1, 0);
      run_cfg("R10 random", a, p, fp, pd, long_st);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule